// File: doc/BRIEF.md
# Serial Receive Character Queue with Fill Triggers

This block sits between the character assembler of one asynchronous serial receiver and the host. Each time the assembler finishes a character, it presents the raw data bits, the received parity bit, and flags for a stop-bit fault and a line break. The block fits the character to the programmed length (5 to 8 bits). It checks parity as odd, even or none, and queues the result with its own three error tags in a 16-entry first-in first-out store.

On the host side, the head of the queue is shown as a valid/ready stream. The same port shows the head entry's tags as line status. Each accepted handshake removes one character. A data request output rises when the number of queued characters reaches one of four programmable thresholds. The write side has no back-pressure: a character offered while the store is full is lost, and a sticky overrun flag is set. The host clears that flag by strobing a line-status read.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the queue is empty: level is 0, out_valid, data_req, overrun and err_any are all 0.
- R2: Characters leave in the order they arrived. The queue holds 16 entries. level counts the stored entries. A push and a pop in the same cycle leave level unchanged.
- R3: cfg_len selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits at or above the selected length are stored and returned as zero.
- R4: cfg_par selects the parity mode: 01 is odd, 10 is even, and 00 or 11 is none. In odd mode an entry's parity tag is set when the ones in the kept data bits plus the parity bit add up to an even number. In even mode the tag is set when they add up to an odd number. With no parity the tag is 0.
- R5: The stop-bit fault and break flags are stored with their character. out_frm_err, out_brk and out_par_err show the tags of the head entry.
- R6: cfg_trig selects the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. data_req is 1 exactly when level is at or above the selected threshold.
- R7: A character offered with in_valid while level is 16 is discarded, and overrun is set. A pop in the same cycle does not prevent the loss. overrun stays set until a cycle with lsr_read. If a new loss happens in the same cycle as lsr_read, overrun stays set.
- R8: err_any is 1 while at least one stored entry carries any error tag.
- R9: fifo_clr empties the queue at the next edge. A character offered in the same cycle is dropped without setting overrun. The threshold selection and overrun are not changed by fifo_clr.
- R10: out_valid is 1 whenever the queue is not empty. An entry is removed only on a cycle with out_valid and out_ready both 1. out_ready while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 2 | Character length select |
| cfg_par | input | 2 | Parity mode select |
| cfg_trig | input | 2 | Data request threshold select |
| fifo_clr | input | 1 | Empty the queue |
| in_valid | input | 1 | A character is offered this cycle |
| in_data | input | 8 | Raw received data bits, LSB first received |
| in_par_bit | input | 1 | Received parity bit |
| in_frm_err | input | 1 | Stop-bit fault on this character |
| in_brk | input | 1 | Break detected on this character |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Host takes the head entry |
| out_data | output | 8 | Head character, upper bits zeroed |
| out_par_err | output | 1 | Head entry parity tag |
| out_frm_err | output | 1 | Head entry stop-bit fault tag |
| out_brk | output | 1 | Head entry break tag |
| lsr_read | input | 1 | Line-status read strobe, clears overrun |
| overrun | output | 1 | Sticky character-loss flag |
| err_any | output | 1 | Some stored entry has an error |
| data_req | output | 1 | Fill level at or above the threshold |
| level | output | 5 | Number of stored entries |

## Verification
The properties treat every input as sampled once per clock edge. fifo_clr, lsr_read and in_valid may be asserted in the same cycle as each other. Configuration fields may change on any cycle, because they only affect the character being pushed or the threshold compared in that cycle. The stimulus drives all inputs half a period away from the rising edge. It mixes long random runs that fill, overflow and drain the queue with directed runs. The directed runs cover every length, parity and threshold code, and clear-versus-push and read-versus-loss collisions.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W  = 8;
  localparam int MIN_LEN = 5;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxf_char_fmt.sv
module rxf_char_fmt
  import uart_rx_pkg::*;
(
  input  logic [CHAR_W-1:0] raw,
  input  logic              par_bit,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        par_sel,
  output logic [CHAR_W-1:0] data,
  output logic              par_err
);
  logic [CHAR_W-1:0] keep;
  logic              ones_odd;

  for (genvar g = 0; g < CHAR_W; g++) begin : g_keep
    assign keep[g] = (g < MIN_LEN + int'(len_sel));
  end

  assign data     = raw & keep;
  assign ones_odd = (^data) ^ par_bit;

  always_comb begin
    unique case (par_mode_e'(par_sel))
      PAR_ODD:  par_err = ~ones_odd;
      PAR_EVEN: par_err = ones_odd;
      default:  par_err = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  rx_entry_t        wr_entry,
  input  logic             pop,
  output rx_entry_t        rd_entry,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             err_pending
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] err_cnt;
  logic             do_push, do_pop, push_bad, pop_bad;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  function automatic logic has_err(input rx_entry_t e);
    return e.brk | e.frm | e.par;
  endfunction

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign do_push  = push && !full && !clr;
  assign do_pop   = pop && !empty && !clr;
  assign push_bad = do_push && has_err(wr_entry);
  assign pop_bad  = do_pop && has_err(mem[rd_ptr]);
  assign rd_entry = empty ? '0 : mem[rd_ptr];
  assign err_pending = (err_cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (do_push) wr_ptr <= step_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      unique case ({push_bad, pop_bad})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxf_trigger.sv
module rxf_trigger #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       sel,
  output logic             req
);
  localparam int THR [4] = '{LVL0, LVL1, LVL2, LVL3};

  logic [CNT_W-1:0] thr_cnt [4];

  for (genvar g = 0; g < 4; g++) begin : g_thr
    assign thr_cnt[g] = CNT_W'(THR[g]);
  end

  assign req = (count >= thr_cnt[sel]);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic [1:0]        cfg_trig,
  input  logic              fifo_clr,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_par_bit,
  input  logic              in_frm_err,
  input  logic              in_brk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_par_err,
  output logic              out_frm_err,
  output logic              out_brk,
  input  logic              lsr_read,
  output logic              overrun,
  output logic              err_any,
  output logic              data_req,
  output logic [LVL_W-1:0]  level
);
  logic [CHAR_W-1:0] fmt_data;
  logic              fmt_perr;
  rx_entry_t         wr_e, rd_e;
  logic              st_full, st_empty, st_err;
  logic              ovr_q, lost;

  rxf_char_fmt u_fmt (
    .raw     (in_data),
    .par_bit (in_par_bit),
    .len_sel (cfg_len),
    .par_sel (cfg_par),
    .data    (fmt_data),
    .par_err (fmt_perr)
  );

  assign wr_e = '{brk: in_brk, frm: in_frm_err, par: fmt_perr, data: fmt_data};

  rxf_store #(.DEPTH(DEPTH), .CNT_W(LVL_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (fifo_clr),
    .push        (in_valid),
    .wr_entry    (wr_e),
    .pop         (out_ready),
    .rd_entry    (rd_e),
    .count       (level),
    .full        (st_full),
    .empty       (st_empty),
    .err_pending (st_err)
  );

  rxf_trigger #(.DEPTH(DEPTH), .CNT_W(LVL_W)) u_trig (
    .count (level),
    .sel   (cfg_trig),
    .req   (data_req)
  );

  assign lost = in_valid && st_full && !fifo_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= (ovr_q && !lsr_read) || lost;
  end

  assign overrun     = ovr_q;
  assign err_any     = st_err;
  assign out_valid   = !st_empty;
  assign out_data    = rd_e.data;
  assign out_par_err = rd_e.par;
  assign out_frm_err = rd_e.frm;
  assign out_brk     = rd_e.brk;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             fifo_clr,
  input logic             lsr_read,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LVL_W-1:0] level,
  input logic             overrun,
  input logic             err_any,
  input logic             data_req
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL);

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && level == FULL && !out_ready && !fifo_clr) |=> level == FULL);

  // R10
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid && !fifo_clr) |=> level == $past(level) - 1'b1);

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && level == FULL && !fifo_clr) |=> overrun);

  // R7
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_read && !(in_valid && level == FULL && !fifo_clr)) |=> !overrun);

  // R7
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(in_valid && level == FULL && !fifo_clr));

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (level == '0 && !out_valid));

  // R8
  err_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !err_any);

  // R6
  req_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> level != '0);
endmodule

bind uart_rx_fifo rxf_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .fifo_clr  (fifo_clr),
  .lsr_read  (lsr_read),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .level     (level),
  .overrun   (overrun),
  .err_any   (err_any),
  .data_req  (data_req)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_len = 2'b11, cfg_par = 2'b00, cfg_trig = 2'b00;
  logic       fifo_clr = 0, in_valid = 0, in_par_bit = 0, in_frm_err = 0, in_brk = 0;
  logic [7:0] in_data = 0;
  logic       out_ready = 0, lsr_read = 0;
  logic       out_valid, out_par_err, out_frm_err, out_brk, overrun, err_any, data_req;
  logic [7:0] out_data;
  logic [4:0] level;

  int total = 0;
  int bad = 0;

  logic [10:0] q[$];
  logic        m_ovr = 0;

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_trig(cfg_trig),
    .fifo_clr(fifo_clr), .in_valid(in_valid), .in_data(in_data), .in_par_bit(in_par_bit),
    .in_frm_err(in_frm_err), .in_brk(in_brk), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_par_err(out_par_err), .out_frm_err(out_frm_err), .out_brk(out_brk),
    .lsr_read(lsr_read), .overrun(overrun), .err_any(err_any), .data_req(data_req), .level(level)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_mask(input logic [7:0] d, input logic [1:0] len);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (i < 5 + int'(len)) ? d[i] : 1'b0;
    return r;
  endfunction

  function automatic logic m_perr(input logic [7:0] d, input logic pb, input logic [1:0] mode);
    int ones = pb;
    for (int i = 0; i < 8; i++) ones += d[i];
    if (mode == 2'b01) return (ones % 2) == 0;
    if (mode == 2'b10) return (ones % 2) == 1;
    return 1'b0;
  endfunction

  function automatic int m_thr(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic m_err_any();
    foreach (q[i]) if (q[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_edge();
    logic full;
    logic [7:0] md;
    full = (q.size() == DEPTH);
    if (lsr_read) m_ovr = 1'b0;
    if (in_valid && full && !fifo_clr) m_ovr = 1'b1;
    if (fifo_clr) q.delete();
    else begin
      if (out_ready && q.size() > 0) void'(q.pop_front());
      if (in_valid && !full) begin
        md = m_mask(in_data, cfg_len);
        q.push_back({in_brk, in_frm_err, m_perr(md, in_par_bit, cfg_par), md});
      end
    end
  endtask

  task automatic compare_all();
    chk("R2 level", level, q.size());
    chk("R10 out_valid", out_valid, q.size() != 0);
    if (q.size() != 0) begin
      chk("R3 out_data", out_data, q[0][7:0]);
      chk("R4 par tag", out_par_err, q[0][8]);
      chk("R5 frame tag", out_frm_err, q[0][9]);
      chk("R5 break tag", out_brk, q[0][10]);
    end
    chk("R6 data_req", data_req, int'(q.size()) >= m_thr(cfg_trig));
    chk("R7 overrun", overrun, m_ovr);
    chk("R8 err_any", err_any, m_err_any());
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    in_valid = 0; out_ready = 0; lsr_read = 0; fifo_clr = 0;
    in_frm_err = 0; in_brk = 0; in_par_bit = 0;
  endtask

  task automatic push(input logic [7:0] d, input logic pb, input logic fe, input logic bi);
    idle();
    in_valid = 1; in_data = d; in_par_bit = pb; in_frm_err = fe; in_brk = bi;
    step();
  endtask

  task automatic pop();
    idle();
    out_ready = 1;
    step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 data_req", data_req, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 err_any", err_any, 0);

    // fill to 16, then overflow
    cfg_len = 2'b11; cfg_par = 2'b10; cfg_trig = 2'b00;
    for (int i = 0; i < DEPTH; i++) push(8'(i * 13 + 1), 1'b0, 1'b0, 1'b0);
    chk("R2 full level", level, 16);
    push(8'hEE, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun after loss", overrun, 1);
    chk("R7 level held", level, 16);
    idle(); lsr_read = 1; step();
    chk("R7 overrun cleared", overrun, 0);
    // loss and read in same cycle: set wins
    idle(); lsr_read = 1; in_valid = 1; in_data = 8'h55; step();
    chk("R7 set wins over read", overrun, 1);
    // pop while pushing on full: pushed char lost
    idle(); out_ready = 1; in_valid = 1; in_data = 8'h77; step();
    chk("R7 level after pop with lost push", level, 15);
    idle(); lsr_read = 1; step();
    for (int i = 0; i < DEPTH; i++) pop();
    // R10 pop on empty
    pop();
    chk("R10 empty pop ignored", level, 0);

    // thresholds
    for (int s = 0; s < 4; s++) begin
      idle(); cfg_trig = 2'(s); fifo_clr = 1; step();
      for (int i = 0; i < 15; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    end

    // R9 clear with push, trig kept
    cfg_trig = 2'b01;
    idle(); fifo_clr = 1; in_valid = 1; in_data = 8'h33; step();
    chk("R9 level after clear", level, 0);
    chk("R9 no overrun from clear", overrun, 0);
    for (int i = 0; i < 4; i++) push(8'h10, 1'b0, 1'b0, 1'b0);
    chk("R9 threshold kept", data_req, 1);
    idle(); fifo_clr = 1; step();

    // lengths and parity modes
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 4; p++) begin
        cfg_len = 2'(l); cfg_par = 2'(p);
        push(8'hFF, 1'b0, 1'b0, 1'b0);
        push(8'hA7, 1'b1, 1'b0, 1'b0);
        pop(); pop();
      end

    // tags and summary
    cfg_par = 2'b00; cfg_len = 2'b11;
    push(8'h01, 0, 0, 0);
    push(8'h02, 0, 1, 0);
    push(8'h00, 0, 1, 1);
    push(8'h03, 0, 0, 0);
    chk("R8 summary with errors", err_any, 1);
    pop(); pop(); pop();
    chk("R8 summary cleared", err_any, 0);
    pop();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      in_valid   = ($urandom % 10) < 6;
      in_data    = 8'($urandom);
      in_par_bit = 1'($urandom);
      in_frm_err = ($urandom % 8) == 0;
      in_brk     = ($urandom % 16) == 0;
      out_ready  = ($urandom % 10) < ((n / 500) % 2 == 0 ? 3 : 7);
      lsr_read   = ($urandom % 10) == 0;
      fifo_clr   = ($urandom % 60) == 0;
      if (($urandom % 50) == 0) begin
        cfg_len = 2'($urandom); cfg_par = 2'($urandom); cfg_trig = 2'($urandom);
      end
      step();
    end
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule